// File: doc/BRIEF.md
# Flipped-product chaotic map iterator

This block iterates a one-dimensional chaotic map in unsigned fixed point. Each new state is built from a tent map and its vertically flipped twin: the current state is folded by the tent map under control parameter r, the folded value is multiplied by one minus itself, and the product is stretched back over the unit interval by a normalising gain. Results that overshoot 1.0 are clipped to exactly 1.0.

Values in [0,1] use a 65-bit word: the low 64 bits hold the fraction and the top bit, when set, stands for exactly 1.0. The gain is a separate 65-bit word with 62 fraction bits, so it spans [0,8). It is the precomputed reciprocal of the normaliser, which is the flipped product evaluated at a state of one half, times a constant. Software computes the gain once, so the datapath needs no divider.

A small controller has three states. IDLE is entered from reset. IDLE goes to SEED on a start pulse, which loads the seed value. SEED goes to RUN on the first enabled cycle, which registers the first result. RUN stays in RUN on each enabled cycle, producing one new state. A start pulse in any state goes to SEED. With the enable low, the current state is held.

Top module: `cmap_flip_iter`

## Requirements
- R1: While reset is high at a clock edge, the state output becomes 0 and the valid flag becomes 0.
- R2: A start pulse loads the seed into the state output on the next edge and clears the valid flag. Start takes priority over the enable.
- R3: In SEED or RUN, an enabled edge replaces the state s with the next state. The fold is u = s when s < 0.5, and 1 − s otherwise. The tent value is t = 2·r·u. The product is p = t·(1 − t). The next state is p·g, where g is the gain. Each product is truncated toward zero to its format: 64 fraction bits for states, 62 fraction bits for g.
- R4: A next state above 1.0 is saturated to exactly 1.0, which is the word with bit 64 set and bits 63..0 zero.
- R5: A seed or r word whose bit 64 is set is read as exactly 1.0, whatever its low bits hold.
- R6: With start and enable low, the state output and the valid flag keep their values.
- R7: Before the first start after reset (IDLE), the enable has no effect. The state stays 0 and valid stays 0.
- R8: The valid flag rises only on an enabled edge after a seed load. It then stays high until the next start or reset.
- R9: The state output never exceeds 1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load the seed and enter SEED |
| en_i | input | 1 | Advance one iteration |
| r_i | input | 65 | Control parameter, 64 fraction bits |
| x0_i | input | 65 | Seed state, 64 fraction bits |
| scale_i | input | 65 | Normalising gain, 62 fraction bits |
| state_o | output | 65 | Current state |
| valid_o | output | 1 | A computed state is present |

## Verification
The checks assume that start is never raised while reset is high, and that r and the gain are held steady in any cycle whose result is compared. The bench drives r and the gain only between edges. It raises start only after reset has been released. It covers both in-range words and words with the top bit set and junk in the low bits. Gains reach almost 8, so the saturation path is driven, and the tent peak at one half is used to produce exact 1.0 and 0.0 results.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2
    } iter_state_e;
endpackage

// File: rtl/cmap_tent_fold.sv
module cmap_tent_fold #(
    parameter int FRAC_BITS = 64
) (
    input  logic [FRAC_BITS:0] x_i,
    input  logic [FRAC_BITS:0] r_i,
    output logic [FRAC_BITS:0] t_o
);
    localparam int W  = FRAC_BITS + 1;
    localparam int HI = 2 * W - W - (FRAC_BITS - 1);
    localparam logic [W-1:0] ONE  = {1'b1, {FRAC_BITS{1'b0}}};
    localparam logic [W-1:0] HALF = {2'b01, {(FRAC_BITS-1){1'b0}}};

    logic [W-1:0]         fold;
    logic [2*W-1:0]       prod;
    logic [HI-1:0]        over;
    logic [W-1:0]         keep;
    logic [FRAC_BITS-2:0] unused_lo_bits;

    // Distance from the nearer edge of the interval, at most one half.
    always_comb begin
        if (x_i < HALF) fold = x_i;
        else            fold = ONE - x_i;
    end

    // 2*r*u: shifting by one bit fewer than the fraction doubles the product.
    assign prod = {{W{1'b0}}, r_i} * {{W{1'b0}}, fold};
    assign {over, keep, unused_lo_bits} = prod;
    assign t_o = (|over || keep > ONE) ? ONE : keep;
endmodule

// File: rtl/cmap_flip_product.sv
module cmap_flip_product #(
    parameter int FRAC_BITS = 64
) (
    input  logic [FRAC_BITS:0] t_i,
    output logic [FRAC_BITS:0] p_o
);
    localparam int W  = FRAC_BITS + 1;
    localparam int HI = 2 * W - W - FRAC_BITS;
    localparam logic [W-1:0] ONE = {1'b1, {FRAC_BITS{1'b0}}};

    logic [W-1:0]         flip;
    logic [2*W-1:0]       prod;
    logic [HI-1:0]        unused_hi_bits;
    logic [FRAC_BITS-1:0] unused_lo_bits;

    assign flip = ONE - t_i;
    assign prod = {{W{1'b0}}, t_i} * {{W{1'b0}}, flip};
    assign {unused_hi_bits, p_o, unused_lo_bits} = prod;
endmodule

// File: rtl/cmap_norm_scale.sv
module cmap_norm_scale #(
    parameter int FRAC_BITS  = 64,
    parameter int SCALE_FRAC = 62
) (
    input  logic [FRAC_BITS:0] p_i,
    input  logic [FRAC_BITS:0] gain_i,
    output logic [FRAC_BITS:0] n_o
);
    localparam int W  = FRAC_BITS + 1;
    localparam int HI = 2 * W - W - SCALE_FRAC;
    localparam logic [W-1:0] ONE = {1'b1, {FRAC_BITS{1'b0}}};

    logic [2*W-1:0]        prod;
    logic [HI-1:0]         over;
    logic [W-1:0]          keep;
    logic [SCALE_FRAC-1:0] unused_lo_bits;

    assign prod = {{W{1'b0}}, p_i} * {{W{1'b0}}, gain_i};
    assign {over, keep, unused_lo_bits} = prod;

    // Clip anything beyond the unit interval to exactly 1.0.
    always_comb begin
        if (|over || keep > ONE) n_o = ONE;
        else                     n_o = keep;
    end
endmodule

// File: rtl/cmap_iter_ctrl.sv
module cmap_iter_ctrl
    import cmap_pkg::*;
#(
    parameter int FRAC_BITS = 64
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  logic               en_i,
    input  logic [FRAC_BITS:0] seed_i,
    input  logic [FRAC_BITS:0] next_i,
    output logic [FRAC_BITS:0] state_o,
    output logic               valid_o
);
    iter_state_e cur_st, nxt_st;

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_IDLE: if (start_i) nxt_st = ST_SEED;
            ST_SEED: begin
                if (start_i)   nxt_st = ST_SEED;
                else if (en_i) nxt_st = ST_RUN;
            end
            ST_RUN:  if (start_i) nxt_st = ST_SEED;
            default: nxt_st = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) cur_st <= ST_IDLE;
        else       cur_st <= nxt_st;
    end

    // Output registers.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_o <= '0;
            valid_o <= 1'b0;
        end else if (start_i) begin
            state_o <= seed_i;
            valid_o <= 1'b0;
        end else if (en_i && cur_st != ST_IDLE) begin
            state_o <= next_i;
            valid_o <= 1'b1;
        end
    end
endmodule

// File: rtl/cmap_flip_iter.sv
module cmap_flip_iter #(
    parameter int FRAC_BITS  = 64,
    parameter int SCALE_FRAC = 62
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic                en_i,
    input  logic [FRAC_BITS:0]  r_i,
    input  logic [FRAC_BITS:0]  x0_i,
    input  logic [FRAC_BITS:0]  scale_i,
    output logic [FRAC_BITS:0]  state_o,
    output logic                valid_o
);
    localparam logic [FRAC_BITS:0] ONE = {1'b1, {FRAC_BITS{1'b0}}};

    logic [FRAC_BITS:0] r_c, seed_c, t_w, p_w, n_w;

    // Any word with the top bit set reads as exactly 1.0.
    assign r_c    = r_i[FRAC_BITS]  ? ONE : r_i;
    assign seed_c = x0_i[FRAC_BITS] ? ONE : x0_i;

    cmap_tent_fold #(.FRAC_BITS(FRAC_BITS)) fold_i (
        .x_i(state_o), .r_i(r_c), .t_o(t_w)
    );

    cmap_flip_product #(.FRAC_BITS(FRAC_BITS)) flip_i (
        .t_i(t_w), .p_o(p_w)
    );

    cmap_norm_scale #(.FRAC_BITS(FRAC_BITS), .SCALE_FRAC(SCALE_FRAC)) norm_i (
        .p_i(p_w), .gain_i(scale_i), .n_o(n_w)
    );

    cmap_iter_ctrl #(.FRAC_BITS(FRAC_BITS)) ctrl_i (
        .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .en_i(en_i),
        .seed_i(seed_c), .next_i(n_w), .state_o(state_o), .valid_o(valid_o)
    );
endmodule

// File: rtl/cmap_flip_iter_chk.sv
module cmap_flip_iter_chk #(
    parameter int FRAC_BITS = 64
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               start_i,
    input logic               en_i,
    input logic [FRAC_BITS:0] x0_i,
    input logic [FRAC_BITS:0] state_o,
    input logic               valid_o
);
    localparam logic [FRAC_BITS:0] ONE = {1'b1, {FRAC_BITS{1'b0}}};

    logic was_rst;
    always_ff @(posedge clk_i) was_rst <= rst_i;

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        was_rst |-> (state_o == '0 && !valid_o));

    assert_seed_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !was_rst) |=> (!valid_o &&
            state_o == ($past(x0_i[FRAC_BITS]) ? ONE : $past(x0_i))));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!start_i && !en_i && !was_rst) |=> ($stable(state_o) && $stable(valid_o)));

    assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!was_rst && $rose(valid_o)) |-> $past(en_i && !start_i));

    assert_in_range_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o <= ONE);
endmodule

bind cmap_flip_iter cmap_flip_iter_chk #(.FRAC_BITS(FRAC_BITS)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .en_i(en_i),
    .x0_i(x0_i), .state_o(state_o), .valid_o(valid_o)
);

// File: tb/cmap_flip_iter_tb_top.sv
`timescale 1ns/1ps
module cmap_flip_iter_tb_top;
    localparam logic [64:0] ONE  = 65'h1_0000_0000_0000_0000;
    localparam logic [64:0] HALF = 65'h0_8000_0000_0000_0000;
    localparam logic [64:0] QTR  = 65'h0_4000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst, start, en;
    logic [64:0] r, x0, scale;
    logic [64:0] state_o;
    logic        valid_o;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [64:0] m_state;
    logic        m_valid;
    bit          m_live;

    always #2.5 clk = ~clk;

    cmap_flip_iter dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .en_i(en),
        .r_i(r), .x0_i(x0), .scale_i(scale),
        .state_o(state_o), .valid_o(valid_o)
    );

    function automatic logic [64:0] unit(input logic [64:0] w);
        return w[64] ? ONE : w;
    endfunction

    // Arithmetic reference on wide integers, written from R3/R4.
    function automatic logic [64:0] ref_step(input logic [64:0] s, input logic [64:0] rr,
                                             input logic [64:0] g);
        logic [199:0] u, t, p, n;
        u = (s < HALF) ? 200'(s) : 200'(ONE - s);
        t = (200'(unit(rr)) * u * 2) / (200'(1) << 64);
        p = (t * (200'(ONE) - t)) / (200'(1) << 64);
        n = (p * 200'(g)) / (200'(1) << 62);
        return (n > 200'(ONE)) ? ONE : n[64:0];
    endfunction

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare after it.
    task automatic step(input string tag);
        @(posedge clk);
        if (rst) begin
            m_state = '0; m_valid = 0; m_live = 0;
        end else if (start) begin
            m_state = unit(x0); m_valid = 0; m_live = 1;
        end else if (en && m_live) begin
            m_state = ref_step(m_state, r, scale); m_valid = 1;
        end
        @(negedge clk);
        chk({tag, " state"}, state_o, m_state);
        chk({tag, " valid"}, {64'd0, valid_o}, {64'd0, m_valid});
    endtask

    task automatic seed(input logic [64:0] xs, input logic [64:0] rr, input logic [64:0] g);
        x0 = xs; r = rr; scale = g; start = 1; en = 0;
        step("R2 seed");
        start = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; start = 0; en = 0; r = HALF; x0 = '0; scale = ONE;
        m_state = '0; m_valid = 0; m_live = 0;
        @(negedge clk);
        step("R1 reset"); step("R1 reset");
        rst = 0;

        // R7: enable in IDLE changes nothing.
        en = 1;
        for (int i = 0; i < 3; i++) step("R7 idle");
        chk("R7 idle state", state_o, '0);

        // R3: exact values. 0.25 -> 0.5 (r=1, gain 2), then 0.5 -> 0.
        seed(QTR, ONE, HALF);
        chk("R2 seed value", state_o, QTR);
        en = 1; step("R3");
        chk("R3 quarter to half", state_o, HALF);
        chk("R8 valid up", {64'd0, valid_o}, 65'd1);
        step("R3");
        chk("R3 peak to zero", state_o, '0);

        // R4: saturation with a gain close to 8.
        seed(HALF, HALF, 65'h1_FFFF_FFFF_FFFF_FFFF);
        en = 1; step("R4");
        chk("R4 saturate", state_o, ONE);

        // R5: junk low bits in r and x0 read as 1.0.
        seed(QTR, 65'h1_0000_0000_0000_1234, HALF);
        en = 1; step("R5");
        chk("R5 r as one", state_o, HALF);
        seed(65'h1_0000_0000_0000_00FF, HALF, ONE);
        chk("R5 seed as one", state_o, ONE);

        // R3/R8: long run from 0.3 with r=0.5, gain 4, gaps in the enable.
        seed(65'h0_4CCC_CCCC_CCCC_CCCD, HALF, ONE);
        for (int i = 0; i < 80; i++) begin
            en = ($urandom % 4) != 0;
            step("R3 run");
        end

        // R6: hold with the enable low.
        en = 0;
        begin
            logic [64:0] held;
            held = state_o;
            step("R6 hold"); step("R6 hold");
            chk("R6 held", state_o, held);
        end

        // R2: start wins over enable; a different r and gain.
        x0 = 65'h0_1234_5678_9ABC_DEF0; r = 65'h0_F000_0000_0000_0000;
        scale = 65'h0_C000_0000_0000_0000; start = 1; en = 1;
        step("R2 priority");
        chk("R2 priority value", state_o, 65'h0_1234_5678_9ABC_DEF0);
        chk("R2 valid clear", {64'd0, valid_o}, '0);
        start = 0;
        for (int i = 0; i < 60; i++) begin
            en = ($urandom % 3) != 0;
            step("R3 run2");
        end

        // R1: reset in the middle of a run.
        rst = 1; step("R1 mid reset");
        chk("R1 cleared", state_o, '0);
        rst = 0; en = 1; step("R7 after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule